// File: doc/BRIEF.md
# Outstanding Write Admission and ID Allocator

This block guards the address channel of an AXI write master. Each write request carries a two-bit memory class. The block lets a request through only when every budget that applies to that class has room. It then gives the write a fixed AWID that depends on the class alone. When a write response comes back on the B channel, the budget held under that response's ID is freed.

A parameter selects the profile. The high-performance profile has a device budget, a shared Normal budget, a cacheable sub-budget and an uncached sub-budget, and it uses four IDs. The area profile has a device budget and a single Normal budget, and it uses two IDs.

Data beats, bursts, cache behaviour and response errors are left to other logic. Only admission counting, ID mapping and completion accounting are modelled here.

Top module: `wr_admit`

## Requirements
- R1: After a synchronous active-high reset, every class sees `req_ready` high, `aw_valid` is low and `writes_saturated` is low.
- R2: The class code maps to the ID as follows: 0 = Strongly-ordered/Device, 1 = Normal cacheable Non-shareable, 2 = Normal Non-cacheable or Shareable, 3 = cache-line eviction. The high-performance profile uses ID = class code. The area profile uses ID 0 for class 0 and ID 1 for every other class.
- R3: At most 15 class-0 writes may be outstanding in either profile.
- R4: In the high-performance profile, at most 24 writes of classes 1, 2 and 3 combined may be outstanding.
- R5: In the high-performance profile, at most 17 writes of classes 1 and 3 combined may be outstanding.
- R6: In the high-performance profile, at most 10 class-2 writes may be outstanding.
- R7: In the area profile, at most 10 writes of classes 1, 2 and 3 combined may be outstanding. This gives a total of 25.
- R8: A request with no room sees `req_ready` low. It is not admitted, and no `aw_valid` appears while it waits. `req_ready` is decoded from the registered counts only, so room freed by a response becomes visible in the cycle after that response.
- R9: A response with `b_valid` high decrements the counter of `b_id`. A response whose ID is outside the profile, or whose counter is zero, changes nothing.
- R10: An admission and a response on the same ID in the same cycle leave that counter unchanged when it is non-zero.
- R11: `writes_saturated` is high exactly when the total outstanding count equals 39 (high-performance) or 25 (area).
- R12: `aw_valid` pulses for one cycle, in the cycle after each handshake with `req_valid` and `req_ready` both high. `aw_id` holds the ID from R2 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_class | input | 2 | Memory class of the request (R2 coding) |
| req_ready | output | 1 | Request may be admitted this cycle |
| aw_valid | output | 1 | Registered pulse: a write was admitted |
| aw_id | output | 2 | ID assigned to the admitted write |
| b_valid | input | 1 | Write response present |
| b_id | input | 2 | ID of the write response |
| writes_saturated | output | 1 | Total outstanding writes at the profile maximum |

## Verification
The hardest state to reach is the one where the cacheable sub-budget is full while the shared Normal budget still has room, and the shared budget is then refilled by uncached writes. Only that order of fills and drains shows which cap is really blocking a request. The bench gets there in steps. It fills the uncached budget, then cacheable writes until the shared cap blocks, then drains a few uncached writes, then tops up with evictions. Saturation comes last, by adding a full device budget on top. Simultaneous admit-and-complete is checked against a budget one below its cap. A dropped decrement would then show up as a premature stall.

// File: rtl/wr_admit_pkg.sv
package wr_admit_pkg;
  localparam int ID_W = 2;
  localparam int MAX_IDS = 4;

  typedef enum logic [1:0] {
    MC_DEVICE   = 2'd0,
    MC_CACHED   = 2'd1,
    MC_UNCACHED = 2'd2,
    MC_EVICT    = 2'd3
  } mem_class_e;

  function automatic logic [ID_W-1:0] class_to_id(input logic [1:0] cls, input bit hp);
    if (hp) return cls;
    return (cls == MC_DEVICE) ? 2'd0 : 2'd1;
  endfunction
endpackage

// File: rtl/wr_admit_idmap.sv
module wr_admit_idmap #(
  parameter bit HIGH_PERF = 1'b1
) (
  input  logic [1:0]                  cls,
  output logic [wr_admit_pkg::ID_W-1:0] id
);
  import wr_admit_pkg::*;

  generate
    if (HIGH_PERF) begin : g_hp
      // One reserved ID per class.
      assign id = cls;
    end else begin : g_area
      // Device keeps its own ID, all Normal traffic shares the second.
      assign id = (cls == MC_DEVICE) ? 2'd0 : 2'd1;
    end
  endgenerate
endmodule

// File: rtl/wr_admit_ctr.sv
module wr_admit_ctr #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);
  logic dec_ok;
  assign dec_ok = dec && (count != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      case ({inc, dec_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/wr_admit_budget.sv
module wr_admit_budget #(
  parameter bit HIGH_PERF     = 1'b1,
  parameter int DEV_MAX       = 15,
  parameter int NORM_MAX      = 24,
  parameter int CACHED_MAX    = 17,
  parameter int UNCACHED_MAX  = 10,
  parameter int AREA_NORM_MAX = 10,
  parameter int CNT_W         = 6
) (
  input  logic [4*CNT_W-1:0] cnt_flat,
  input  logic [1:0]         cls,
  output logic               ok
);
  import wr_admit_pkg::*;

  localparam int SW = CNT_W + 2;
  localparam logic [SW-1:0] L_DEV  = SW'(DEV_MAX);
  localparam logic [SW-1:0] L_NORM = SW'(NORM_MAX);
  localparam logic [SW-1:0] L_CACH = SW'(CACHED_MAX);
  localparam logic [SW-1:0] L_UNC  = SW'(UNCACHED_MAX);
  localparam logic [SW-1:0] L_AREA = SW'(AREA_NORM_MAX);

  logic [SW-1:0] c0, c1, c2, c3;
  assign c0 = SW'(cnt_flat[0*CNT_W +: CNT_W]);
  assign c1 = SW'(cnt_flat[1*CNT_W +: CNT_W]);
  assign c2 = SW'(cnt_flat[2*CNT_W +: CNT_W]);
  assign c3 = SW'(cnt_flat[3*CNT_W +: CNT_W]);

  generate
    if (HIGH_PERF) begin : g_hp
      logic [SW-1:0] norm_sum, cach_sum;
      logic          norm_room;
      assign norm_sum  = c1 + c2 + c3;
      assign cach_sum  = c1 + c3;
      assign norm_room = norm_sum < L_NORM;
      always_comb begin
        case (cls)
          MC_DEVICE:   ok = c0 < L_DEV;
          MC_UNCACHED: ok = norm_room && (c2 < L_UNC);
          default:     ok = norm_room && (cach_sum < L_CACH);
        endcase
      end
    end else begin : g_area
      assign ok = (cls == MC_DEVICE) ? (c0 < L_DEV) : (c1 < L_AREA);
    end
  endgenerate
endmodule

// File: rtl/wr_admit.sv
module wr_admit #(
  parameter bit HIGH_PERF     = 1'b1,
  parameter int DEV_MAX       = 15,
  parameter int NORM_MAX      = 24,
  parameter int CACHED_MAX    = 17,
  parameter int UNCACHED_MAX  = 10,
  parameter int AREA_NORM_MAX = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_class,
  output logic       req_ready,
  output logic       aw_valid,
  output logic [1:0] aw_id,
  input  logic       b_valid,
  input  logic [1:0] b_id,
  output logic       writes_saturated
);
  import wr_admit_pkg::*;

  localparam int NUM_ID    = HIGH_PERF ? 4 : 2;
  localparam int TOTAL_MAX = DEV_MAX + (HIGH_PERF ? NORM_MAX : AREA_NORM_MAX);
  localparam int CNT_W     = $clog2(TOTAL_MAX + 1);
  localparam int SW        = CNT_W + 2;
  localparam logic [SW-1:0] L_TOTAL = SW'(TOTAL_MAX);

  logic [4*CNT_W-1:0] cnt_flat;
  logic [SW-1:0]      total_cnt;
  logic [ID_W-1:0]    req_id;
  logic               admit;

  wr_admit_idmap #(.HIGH_PERF(HIGH_PERF)) u_idmap (
    .cls (req_class),
    .id  (req_id)
  );

  wr_admit_budget #(
    .HIGH_PERF     (HIGH_PERF),
    .DEV_MAX       (DEV_MAX),
    .NORM_MAX      (NORM_MAX),
    .CACHED_MAX    (CACHED_MAX),
    .UNCACHED_MAX  (UNCACHED_MAX),
    .AREA_NORM_MAX (AREA_NORM_MAX),
    .CNT_W         (CNT_W)
  ) u_budget (
    .cnt_flat (cnt_flat),
    .cls      (req_class),
    .ok       (req_ready)
  );

  assign admit = req_valid && req_ready;

  generate
    for (genvar g = 0; g < MAX_IDS; g++) begin : g_id
      if (g < NUM_ID) begin : g_on
        wr_admit_ctr #(.CNT_W(CNT_W)) u_ctr (
          .clk   (clk),
          .rst   (rst),
          .inc   (admit && (req_id == ID_W'(g))),
          .dec   (b_valid && (b_id == ID_W'(g))),
          .count (cnt_flat[g*CNT_W +: CNT_W])
        );
      end else begin : g_off
        assign cnt_flat[g*CNT_W +: CNT_W] = '0;
      end
    end
  endgenerate

  always_comb begin
    total_cnt = '0;
    for (int i = 0; i < MAX_IDS; i++) begin
      total_cnt = total_cnt + SW'(cnt_flat[i*CNT_W +: CNT_W]);
    end
  end

  // Decoded from the counter registers only.
  assign writes_saturated = (total_cnt == L_TOTAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_valid <= 1'b0;
      aw_id    <= '0;
    end else begin
      aw_valid <= admit;
      if (admit) aw_id <= req_id;
    end
  end
endmodule

// File: rtl/wr_admit_chk.sv
module wr_admit_chk #(
  parameter bit HIGH_PERF     = 1'b1,
  parameter int DEV_MAX       = 15,
  parameter int NORM_MAX      = 24,
  parameter int CACHED_MAX    = 17,
  parameter int UNCACHED_MAX  = 10,
  parameter int AREA_NORM_MAX = 10,
  parameter int CNT_W         = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [1:0]         req_class,
  input logic               aw_valid,
  input logic               b_valid,
  input logic [1:0]         b_id,
  input logic               writes_saturated,
  input logic [4*CNT_W-1:0] cnt_flat,
  input logic [CNT_W+1:0]   total_cnt
);
  import wr_admit_pkg::*;
  localparam int SW = CNT_W + 2;
  localparam int NMAX = HIGH_PERF ? NORM_MAX : AREA_NORM_MAX;
  localparam int TOTAL_MAX = DEV_MAX + NMAX;

  logic [SW-1:0] c0, c1, c2, c3, nsum;
  assign c0 = SW'(cnt_flat[0*CNT_W +: CNT_W]);
  assign c1 = SW'(cnt_flat[1*CNT_W +: CNT_W]);
  assign c2 = SW'(cnt_flat[2*CNT_W +: CNT_W]);
  assign c3 = SW'(cnt_flat[3*CNT_W +: CNT_W]);
  assign nsum = c1 + c2 + c3;

  logic           handshake;
  logic [CNT_W-1:0] hit_cnt;
  assign handshake = req_valid && req_ready;
  assign hit_cnt   = cnt_flat[b_id*CNT_W +: CNT_W];

  p_dev_cap_r3: assert property (@(posedge clk) disable iff (rst)
    c0 <= SW'(DEV_MAX));

  p_norm_cap_r4: assert property (@(posedge clk) disable iff (rst)
    nsum <= SW'(NMAX));

  p_cached_cap_r5: assert property (@(posedge clk) disable iff (rst)
    !HIGH_PERF || (c1 + c3 <= SW'(CACHED_MAX)));

  p_uncached_cap_r6: assert property (@(posedge clk) disable iff (rst)
    !HIGH_PERF || (c2 <= SW'(UNCACHED_MAX)));

  p_total_cap_r11: assert property (@(posedge clk) disable iff (rst)
    total_cnt <= SW'(TOTAL_MAX));

  p_sat_blocks_r11: assert property (@(posedge clk) disable iff (rst)
    writes_saturated |-> !req_ready);

  p_aw_after_hs_r12: assert property (@(posedge clk) disable iff (rst)
    handshake |=> aw_valid);

  p_no_aw_r8: assert property (@(posedge clk) disable iff (rst)
    !handshake |=> !aw_valid);

  p_net_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (handshake && b_valid && (b_id == class_to_id(req_class, HIGH_PERF)) && (hit_cnt != '0))
      |=> $stable(total_cnt));
endmodule

bind wr_admit wr_admit_chk #(
  .HIGH_PERF     (HIGH_PERF),
  .DEV_MAX       (DEV_MAX),
  .NORM_MAX      (NORM_MAX),
  .CACHED_MAX    (CACHED_MAX),
  .UNCACHED_MAX  (UNCACHED_MAX),
  .AREA_NORM_MAX (AREA_NORM_MAX),
  .CNT_W         (CNT_W)
) u_chk (
  .clk              (clk),
  .rst              (rst),
  .req_valid        (req_valid),
  .req_ready        (req_ready),
  .req_class        (req_class),
  .aw_valid         (aw_valid),
  .b_valid          (b_valid),
  .b_id             (b_id),
  .writes_saturated (writes_saturated),
  .cnt_flat         (cnt_flat),
  .total_cnt        (total_cnt)
);

// File: tb/test_wr_admit.sv
module test_wr_admit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] req_class = 2'd0;
  logic [1:0] b_id = 2'd0;
  logic vh = 1'b0, va = 1'b0, bh = 1'b0, ba = 1'b0;

  logic hp_ready, hp_awv, hp_sat, ar_ready, ar_awv, ar_sat;
  logic [1:0] hp_awid, ar_awid;

  always #(CLK_PERIOD/2) clk = ~clk;

  wr_admit #(.HIGH_PERF(1'b1)) i_wr_admit (
    .clk(clk), .rst(rst), .req_valid(vh), .req_class(req_class), .req_ready(hp_ready),
    .aw_valid(hp_awv), .aw_id(hp_awid), .b_valid(bh), .b_id(b_id), .writes_saturated(hp_sat));

  wr_admit #(.HIGH_PERF(1'b0)) i_wr_admit_area (
    .clk(clk), .rst(rst), .req_valid(va), .req_class(req_class), .req_ready(ar_ready),
    .aw_valid(ar_awv), .aw_id(ar_awid), .b_valid(ba), .b_id(b_id), .writes_saturated(ar_sat));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m [2][4];  // model counts per profile and ID

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nid(input bit ar); return ar ? 2 : 4; endfunction
  function automatic int exp_id(input bit ar, input int cls);
    if (!ar) return cls;
    return (cls == 0) ? 0 : 1;
  endfunction
  function automatic bit exp_ok(input bit ar, input int cls);
    if (cls == 0) return m[ar][0] < 15;
    if (ar) return m[1][1] < 10;
    if (m[0][1] + m[0][2] + m[0][3] >= 24) return 0;
    if (cls == 2) return m[0][2] < 10;
    return (m[0][1] + m[0][3]) < 17;
  endfunction
  function automatic bit exp_sat(input bit ar);
    int t = 0;
    for (int i = 0; i < 4; i++) t += m[ar][i];
    return t == (ar ? 25 : 39);
  endfunction

  function automatic bit rdy(input bit ar); return ar ? ar_ready : hp_ready; endfunction
  function automatic bit awv(input bit ar); return ar ? ar_awv : hp_awv; endfunction
  function automatic int awid(input bit ar); return ar ? int'(ar_awid) : int'(hp_awid); endfunction
  function automatic bit sat(input bit ar); return ar ? ar_sat : hp_sat; endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; vh = 0; va = 0; bh = 0; ba = 0;
    for (int p = 0; p < 2; p++) for (int i = 0; i < 4; i++) m[p][i] = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // One request; expectation from the model. Tags: R3-R7 caps via exp_ok, R2/R12 id, R11 sat.
  task automatic admit(input bit ar, input int cls, input string tag);
    bit ok;
    @(negedge clk);
    req_class = 2'(cls);
    if (ar) va = 1; else vh = 1;
    ok = exp_ok(ar, cls);
    #1 chk(rdy(ar) == ok, {tag, " ready"}, rdy(ar), ok);
    @(posedge clk); #1;
    vh = 0; va = 0;
    if (ok) m[ar][exp_id(ar, cls)]++;
    chk(awv(ar) == ok, {tag, " R12 aw_valid"}, awv(ar), ok);
    if (ok) chk(awid(ar) == exp_id(ar, cls), {tag, " R2 aw_id"}, awid(ar), exp_id(ar, cls));
    chk(sat(ar) == exp_sat(ar), {tag, " R11 saturated"}, sat(ar), exp_sat(ar));
  endtask

  task automatic complete(input bit ar, input int id);
    @(negedge clk);
    b_id = 2'(id);
    if (ar) ba = 1; else bh = 1;
    @(posedge clk); #1;
    bh = 0; ba = 0;
    if (id < nid(ar) && m[ar][id] > 0) m[ar][id]--;
  endtask

  task automatic t_reset();
    do_reset();
    for (int c = 0; c < 4; c++) begin
      req_class = 2'(c);
      #1 chk(hp_ready && ar_ready, "R1 ready after reset", hp_ready, 1);
    end
    chk(!hp_awv && !ar_awv, "R1 aw_valid after reset", hp_awv, 0);
    chk(!hp_sat && !ar_sat, "R1 saturated after reset", hp_sat, 0);
  endtask

  task automatic t_idmap();
    do_reset();
    for (int c = 0; c < 4; c++) admit(0, c, "R2 hp map");
    for (int c = 0; c < 4; c++) admit(1, c, "R2 area map");
    // R9: responses free the counts; confirmed through the model-driven caps later.
    for (int c = 0; c < 4; c++) complete(0, c);
    complete(1, 0); for (int k = 0; k < 3; k++) complete(1, 1);
    for (int c = 0; c < 4; c++) admit(0, c, "R9 after release");
  endtask

  task automatic t_dev_stall();
    do_reset();
    for (int k = 0; k < 15; k++) admit(0, 0, "R3 dev fill");
    admit(0, 0, "R3 dev over cap");
    // R8: held request stays stalled.
    @(negedge clk); req_class = 2'd0; vh = 1;
    for (int k = 0; k < 3; k++) begin
      #1 chk(!hp_ready, "R8 stall ready", hp_ready, 0);
      @(posedge clk); #1 chk(!hp_awv, "R8 stall no aw", hp_awv, 0);
      @(negedge clk);
    end
    bh = 1; b_id = 2'd0;
    #1 chk(!hp_ready, "R8 ready same cycle as response", hp_ready, 0);
    @(posedge clk); #1;
    bh = 0;
    chk(!hp_awv, "R8 no aw on response cycle", hp_awv, 0);
    chk(hp_ready, "R8 ready after response", hp_ready, 1);
    @(posedge clk); #1;
    vh = 0;
    chk(hp_awv && hp_awid == 2'd0, "R8 held request admitted", hp_awv, 1);
    admit(0, 0, "R3 dev full again");
    // R10: at 14, admit and complete together; cap must still allow exactly one more.
    complete(0, 0);
    @(negedge clk); req_class = 2'd0; vh = 1; bh = 1; b_id = 2'd0;
    @(posedge clk); #1; vh = 0; bh = 0;
    chk(hp_awv, "R10 combined cycle admitted", hp_awv, 1);
    admit(0, 0, "R10 one slot left");
    admit(0, 0, "R10 then full");
  endtask

  task automatic t_normal_caps();
    do_reset();
    complete(0, 1);  // R9: response to an empty counter is ignored
    for (int k = 0; k < 10; k++) admit(0, 2, "R6 uncached fill");
    admit(0, 2, "R6 uncached over cap");
    chk(!hp_awv, "R6 no aw when blocked", hp_awv, 0);
    for (int k = 0; k < 14; k++) admit(0, 1, "R4 cached fill");
    admit(0, 1, "R4 shared cap blocks cached");
    admit(0, 3, "R4 shared cap blocks evict");
    for (int k = 0; k < 3; k++) complete(0, 2);
    for (int k = 0; k < 3; k++) admit(0, 3, "R5 evict topup");
    complete(0, 2);
    admit(0, 1, "R5 cacheable cap blocks cached");
    admit(0, 3, "R5 cacheable cap blocks evict");
    admit(0, 2, "R6 uncached uses last shared slot");
    for (int k = 0; k < 15; k++) admit(0, 0, "R11 dev to saturation");
    chk(hp_sat, "R11 saturated at 39", hp_sat, 1);
    complete(0, 0);
    #1 chk(!hp_sat, "R11 saturated clears", hp_sat, 0);
  endtask

  task automatic t_area();
    do_reset();
    for (int k = 0; k < 10; k++) admit(1, k % 3 + 1, "R7 area normal fill");
    for (int c = 1; c < 4; c++) admit(1, c, "R7 area normal over cap");
    for (int k = 0; k < 15; k++) admit(1, 0, "R11 area dev fill");
    chk(ar_sat, "R11 area saturated at 25", ar_sat, 1);
    complete(1, 2);  // R9: ID outside area profile ignored
    admit(1, 2, "R9 out-of-profile response ignored");
    complete(1, 1);
    admit(1, 2, "R9 area release admits");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idmap();
    t_dev_stall();
    t_normal_caps();
    t_area();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule